// File: doc/BRIEF.md
# Four-Channel Cascadable Interval Timer

This block holds four 16-bit up-counting timers, numbered 0 to 3, behind a small synchronous register port. Each timer has two registers: a control register and a data register. A read of the data register returns the live count. A write to it sets only the stored reload value. The reload value is copied into the count in two cases: when the timer is switched on, and each time the count rolls past its maximum.

Each timer advances from one of two sources. The first is its own prescaler, which divides the system clock by 1, 64, 256 or 1024. The second is the overflow of the next lower-numbered timer, called cascade mode. Timer 0 has no lower neighbour, so it ignores its cascade bit. A cascaded timer whose lower timer is switched off gets no ticks. This lets software pause a count without losing it. An overflow can produce a one-cycle interrupt pulse for that timer.

Top module: `qtmr_quad`

## Requirements
- R1: The address is split into two fields. addr[0] = 0 selects the data register and addr[0] = 1 selects the control register. addr[2:1] selects the timer. The control register fields are: bits [1:0] scale, bit 2 cascade, bit 6 interrupt enable, bit 7 enable. A control read returns these bits and reads 0 in bits 3 to 5 and above. After reset every count, reload value, control register and irq output is 0.
- R2: A data read returns the timer's current count. A data write stores the reload value and does not change the count.
- R3: While a timer's enable bit is 0, its count holds its last value.
- R4: A control write that takes enable from 0 to 1 loads the reload value into the count on that clock edge. A control write while the timer is already enabled does not reload.
- R5: With cascade inactive, scale codes 00, 01, 10 and 11 give one tick every 1, 64, 256 and 1024 cycles. The prescaler is cleared on the enabling edge. The count first reaches reload+1 on the N-th clock edge after that edge, where N is the scale period.
- R6: A tick while the count is 0xFFFF is an overflow. The count then takes the reload value, not 0.
- R7: If interrupt enable is 1, irq[i] is high for exactly the one cycle that follows the overflow edge. If interrupt enable is 0, an overflow leaves irq[i] low.
- R8: A timer n ≥ 1 with cascade set advances by one on the same clock edge on which timer n−1 overflows. Its prescaler has no effect.
- R9: Timer 0 ignores its cascade bit and always ticks from its prescaler.
- R10: A cascaded, enabled timer whose lower timer is disabled holds its count. Clearing cascade later resumes prescaled ticking from the held count, with no reload.
- R11: A data write on the same edge as an overflow makes the newly written value the one loaded into the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; the write takes effect on the rising edge |
| addr | input | 3 | {timer index, control/data select} |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register (combinational) |
| irq | output | 4 | One-cycle overflow interrupt pulse per timer |

## Verification
Counting is tried with each of the four scale codes and sampled one edge before and on the edge where the first tick is due. This tells a correct full-period first tick apart from an off-by-one prescaler. Overflow is tried from a reload just below the maximum, with interrupt enable both set and clear. A data write is also made exactly on the overflow edge, which separates the reload-forwarding path from the stale-reload path. Cascade is tried in three ways: with a running lower timer, with a disabled lower timer, and on timer 0. These show chained ticking, the pause-and-resume behaviour with no reload, and the timer-0 exception.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

   localparam int CTL_SCALE_LSB = 0;
   localparam int CTL_CASC_BIT  = 2;
   localparam int CTL_IE_BIT    = 6;
   localparam int CTL_EN_BIT    = 7;
   localparam int CTL_BYTE_W    = 8;

   typedef enum logic [1:0] {
      SCALE_P1    = 2'b00,
      SCALE_P64   = 2'b01,
      SCALE_P256  = 2'b10,
      SCALE_P1024 = 2'b11
   } scale_e;

   typedef struct packed {
      logic   en;
      logic   ie;
      logic   casc;
      scale_e scale;
   } ctl_t;

   function automatic logic [CTL_BYTE_W-1:0] ctl_to_byte(input ctl_t c);
      logic [CTL_BYTE_W-1:0] b;
      b = '0;
      b[CTL_SCALE_LSB +: 2] = c.scale;
      b[CTL_CASC_BIT]       = c.casc;
      b[CTL_IE_BIT]         = c.ie;
      b[CTL_EN_BIT]         = c.en;
      return b;
   endfunction

endpackage

// File: rtl/qtmr_prescale.sv
module qtmr_prescale
   import qtmr_pkg::*;
#(
   parameter int SH1 = 6,
   parameter int SH2 = 8,
   parameter int SH3 = 10
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clr,
   input  logic   run,
   input  scale_e scale,
   output logic   tick
);

   localparam int PW = SH3;
   localparam logic [PW-1:0] MASK1 = PW'((1 << SH1) - 1);
   localparam logic [PW-1:0] MASK2 = PW'((1 << SH2) - 1);
   localparam logic [PW-1:0] MASK3 = PW'((1 << SH3) - 1);

   if (!(SH1 >= 1 && SH2 >= SH1 && SH3 >= SH2 && SH3 <= 16)) begin : g_bad_shift
      $error("qtmr_prescale: shifts must satisfy 1 <= SH1 <= SH2 <= SH3 <= 16");
   end

   logic [PW-1:0] pre_q;
   logic [PW-1:0] mask;

   always_comb begin
      unique case (scale)
         SCALE_P1:    mask = '0;
         SCALE_P64:   mask = MASK1;
         SCALE_P256:  mask = MASK2;
         default:     mask = MASK3;
      endcase
   end

   assign tick = run && ((pre_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n)    pre_q <= '0;
      else if (clr)  pre_q <= '0;
      else if (run)  pre_q <= pre_q + 1'b1;
   end

endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel
   import qtmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SH1     = 6,
   parameter int SH2     = 8,
   parameter int SH3     = 10,
   parameter bit CASC_OK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_data,
   input  logic             wr_ctl,
   input  logic [CNT_W-1:0] wdata,
   input  logic             lower_ovf,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] reload,
   output ctl_t             ctl,
   output logic             start,
   output logic             ovf,
   output logic             irq
);

   if (CNT_W < CTL_BYTE_W) begin : g_bad_width
      $error("qtmr_channel: CNT_W must hold the control byte");
   end

   ctl_t             ctl_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rld_q;
   logic [CNT_W-1:0] rld_nxt;
   logic             irq_q;
   logic             use_casc;
   logic             pre_tick;
   logic             tick;

   if (CASC_OK) begin : g_casc
      assign use_casc = ctl_q.casc;
   end else begin : g_nocasc
      assign use_casc = 1'b0;
   end

   assign start = wr_ctl && wdata[CTL_EN_BIT] && !ctl_q.en;

   qtmr_prescale #(.SH1(SH1), .SH2(SH2), .SH3(SH3)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .run   (ctl_q.en),
      .scale (ctl_q.scale),
      .tick  (pre_tick)
   );

   assign tick    = use_casc ? lower_ovf : pre_tick;
   assign ovf     = ctl_q.en && tick && (cnt_q == '1);
   assign rld_nxt = wr_data ? wdata : rld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cnt_q <= '0;
         rld_q <= '0;
         irq_q <= 1'b0;
      end else begin
         rld_q <= rld_nxt;
         irq_q <= ovf && ctl_q.ie;
         if (wr_ctl) begin
            ctl_q.en    <= wdata[CTL_EN_BIT];
            ctl_q.ie    <= wdata[CTL_IE_BIT];
            ctl_q.casc  <= wdata[CTL_CASC_BIT];
            ctl_q.scale <= scale_e'(wdata[CTL_SCALE_LSB +: 2]);
         end
         if (start || ovf)           cnt_q <= rld_nxt;
         else if (ctl_q.en && tick)  cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt    = cnt_q;
   assign reload = rld_q;
   assign ctl    = ctl_q;
   assign irq    = irq_q;

endmodule

// File: rtl/qtmr_quad.sv
module qtmr_quad
   import qtmr_pkg::*;
#(
   parameter int NUM_TIMERS = 4,
   parameter int CNT_W      = 16,
   parameter int SH1        = 6,
   parameter int SH2        = 8,
   parameter int SH3        = 10,
   localparam int IW        = $clog2(NUM_TIMERS),
   localparam int AW        = IW + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         addr,
   input  logic [CNT_W-1:0]      wdata,
   output logic [CNT_W-1:0]      rdata,
   output logic [NUM_TIMERS-1:0] irq
);

   if (NUM_TIMERS < 2) begin : g_bad_num
      $error("qtmr_quad: NUM_TIMERS must be at least 2");
   end

   logic [IW-1:0]         sel_idx;
   logic                  sel_ctl;
   logic [CNT_W-1:0]      cnt_w [NUM_TIMERS];
   logic [CNT_W-1:0]      rld_w [NUM_TIMERS];
   ctl_t                  ctl_w [NUM_TIMERS];
   logic [NUM_TIMERS-1:0] ovf_w;
   logic [NUM_TIMERS-1:0] start_w;
   logic [NUM_TIMERS-1:0] wr_data_w;
   logic [NUM_TIMERS-1:0] wr_ctl_w;
   logic [NUM_TIMERS-1:0] en_w;
   logic [NUM_TIMERS-1:0] casc_w;
   logic [NUM_TIMERS-1:0] ie_w;

   assign sel_idx = addr[AW-1:1];
   assign sel_ctl = addr[0];

   for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
      logic lower;
      if (g == 0) begin : g_first
         assign lower = 1'b0;
      end else begin : g_chain
         assign lower = ovf_w[g-1];
      end

      assign wr_data_w[g] = wr_en && !sel_ctl && (sel_idx == IW'(g));
      assign wr_ctl_w[g]  = wr_en &&  sel_ctl && (sel_idx == IW'(g));

      qtmr_channel #(
         .CNT_W(CNT_W), .SH1(SH1), .SH2(SH2), .SH3(SH3), .CASC_OK(g != 0)
      ) i_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_data   (wr_data_w[g]),
         .wr_ctl    (wr_ctl_w[g]),
         .wdata     (wdata),
         .lower_ovf (lower),
         .cnt       (cnt_w[g]),
         .reload    (rld_w[g]),
         .ctl       (ctl_w[g]),
         .start     (start_w[g]),
         .ovf       (ovf_w[g]),
         .irq       (irq[g])
      );

      assign en_w[g]   = ctl_w[g].en;
      assign casc_w[g] = ctl_w[g].casc;
      assign ie_w[g]   = ctl_w[g].ie;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_TIMERS; i++) begin
         if (sel_idx == IW'(i)) begin
            rdata = sel_ctl ? CNT_W'(ctl_to_byte(ctl_w[i])) : cnt_w[i];
         end
      end
   end

endmodule

// File: rtl/qtmr_quad_chk.sv
module qtmr_quad_chk #(
   parameter int NUM_TIMERS = 4,
   parameter int CNT_W      = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [CNT_W-1:0]      wdata,
   input logic [CNT_W-1:0]      cnt    [NUM_TIMERS],
   input logic [CNT_W-1:0]      reload [NUM_TIMERS],
   input logic [NUM_TIMERS-1:0] en,
   input logic [NUM_TIMERS-1:0] casc,
   input logic [NUM_TIMERS-1:0] ie,
   input logic [NUM_TIMERS-1:0] ovf,
   input logic [NUM_TIMERS-1:0] start,
   input logic [NUM_TIMERS-1:0] wr_data,
   input logic [NUM_TIMERS-1:0] irq
);

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_p

      p_reload_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_data[i] |=> reload[i] == $past(wdata));

      p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!en[i] && !start[i]) |=> $stable(cnt[i]));

      p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (start[i] && !wr_data[i]) |=> cnt[i] == $past(reload[i]));

      p_ovf_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf[i] && !wr_data[i] && !start[i]) |=> cnt[i] == $past(reload[i]));

      p_ovf_fwd_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf[i] && wr_data[i]) |=> cnt[i] == $past(wdata));

      p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf[i] && ie[i]) |=> irq[i]);

      if (i > 0) begin : g_c
         p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && casc[i] && !en[i-1] && !start[i]) |=> $stable(cnt[i]));

         p_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && casc[i] && ovf[i-1] && !ovf[i] && !start[i])
               |=> cnt[i] == $past(cnt[i]) + CNT_W'(1));
      end
   end

endmodule

bind qtmr_quad qtmr_quad_chk #(.NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wdata   (wdata),
   .cnt     (cnt_w),
   .reload  (rld_w),
   .en      (en_w),
   .casc    (casc_w),
   .ie      (ie_w),
   .ovf     (ovf_w),
   .start   (start_w),
   .wr_data (wr_data_w),
   .irq     (irq)
);

// File: tb/test_qtmr_quad.sv
module test_qtmr_quad;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   qtmr_quad i_qtmr_quad (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input int idx, input bit ctl, input logic [15:0] d);
      addr  = {idx[1:0], ctl};
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int idx, input bit ctl, output logic [15:0] v);
      addr = {idx[1:0], ctl};
      #1;
      v = rdata;
   endtask

   task automatic expect_cnt(input string req, input int idx, input logic [15:0] exp);
      logic [15:0] v;
      rd(idx, 1'b0, v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      for (int i = 0; i < 4; i++) begin
         expect_cnt("R1 reset count", i, 16'h0000);
         rd(i, 1'b1, v);
         check("R1 reset control", v, 16'h0000);
      end
      check("R1 reset irq", {12'h0, irq}, 16'h0000);
   endtask

   task automatic t_ctl_readback();
      logic [15:0] v;
      wr(1, 1'b1, 16'h007F);
      rd(1, 1'b1, v);
      check("R1 control readback", v, 16'h0047);
      wr(1, 1'b1, 16'h0000);
   endtask

   task automatic t_freeze();
      wr(0, 1'b0, 16'h1000);
      expect_cnt("R2 data write keeps count", 0, 16'h0000);
      wr(0, 1'b1, 16'h0080);
      expect_cnt("R4 enable loads reload", 0, 16'h1000);
      wr(0, 1'b1, 16'h0000);
      expect_cnt("R3 frozen after disable", 0, 16'h1001);
      repeat (10) @(negedge clk);
      expect_cnt("R3 still frozen", 0, 16'h1001);
      wr(0, 1'b0, 16'h2222);
      expect_cnt("R2 write while disabled", 0, 16'h1001);
      wr(0, 1'b1, 16'h0080);
      expect_cnt("R4 re-enable loads new reload", 0, 16'h2222);
      wr(0, 1'b1, 16'h0000);
   endtask

   task automatic t_no_rearm();
      wr(1, 1'b0, 16'h0005);
      wr(1, 1'b1, 16'h0083);
      wr(1, 1'b0, 16'h0009);
      expect_cnt("R2 write while enabled", 1, 16'h0005);
      wr(1, 1'b1, 16'h0083);
      expect_cnt("R4 no reload when already enabled", 1, 16'h0005);
      wr(1, 1'b1, 16'h0000);
   endtask

   task automatic t_prescale();
      for (int s = 0; s < 4; s++) begin
         int period;
         period = (s == 0) ? 1 : (s == 1) ? 64 : (s == 2) ? 256 : 1024;
         wr(2, 1'b0, 16'h0300);
         wr(2, 1'b1, 16'h0080 | 16'(s));
         expect_cnt("R5 count at enable", 2, 16'h0300);
         repeat (period - 1) @(negedge clk);
         expect_cnt("R5 no tick before period", 2, 16'h0300);
         @(negedge clk);
         expect_cnt("R5 tick at period", 2, 16'h0301);
         wr(2, 1'b1, 16'h0000);
      end
   endtask

   task automatic t_overflow_irq();
      wr(0, 1'b0, 16'hFFFE);
      wr(0, 1'b1, 16'h00C0);
      @(negedge clk);
      expect_cnt("R6 reach max", 0, 16'hFFFF);
      check("R7 no irq before overflow", {15'h0, irq[0]}, 16'h0000);
      @(negedge clk);
      expect_cnt("R6 overflow reloads", 0, 16'hFFFE);
      check("R7 irq pulse after overflow", {15'h0, irq[0]}, 16'h0001);
      @(negedge clk);
      check("R7 irq lasts one cycle", {15'h0, irq[0]}, 16'h0000);
      wr(0, 1'b1, 16'h0000);
      @(negedge clk);
   endtask

   task automatic t_ovf_write();
      wr(0, 1'b0, 16'hFFFE);
      wr(0, 1'b1, 16'h0080);
      @(negedge clk);
      wr(0, 1'b0, 16'h1234);
      expect_cnt("R11 overflow loads new write", 0, 16'h1234);
      check("R7 no irq when disabled", {15'h0, irq[0]}, 16'h0000);
      wr(0, 1'b1, 16'h0000);
   endtask

   task automatic t_timer0_casc();
      wr(0, 1'b0, 16'h0020);
      wr(0, 1'b1, 16'h0084);
      repeat (3) @(negedge clk);
      expect_cnt("R9 timer 0 ignores cascade", 0, 16'h0023);
      wr(0, 1'b1, 16'h0000);
   endtask

   task automatic t_chain();
      wr(0, 1'b0, 16'hFFFE);
      wr(1, 1'b0, 16'h0010);
      wr(1, 1'b1, 16'h0084);
      wr(0, 1'b1, 16'h0080);
      expect_cnt("R8 cascaded count at start", 1, 16'h0010);
      repeat (2) @(negedge clk);
      expect_cnt("R8 tick on lower overflow", 1, 16'h0011);
      expect_cnt("R6 lower timer reloaded", 0, 16'hFFFE);
      @(negedge clk);
      expect_cnt("R8 prescaler ignored", 1, 16'h0011);
      @(negedge clk);
      expect_cnt("R8 second lower overflow", 1, 16'h0012);
      wr(0, 1'b1, 16'h0000);
      wr(1, 1'b1, 16'h0000);
   endtask

   task automatic t_pause();
      wr(3, 1'b0, 16'h0100);
      wr(3, 1'b1, 16'h0084);
      repeat (20) @(negedge clk);
      expect_cnt("R10 held while lower disabled", 3, 16'h0100);
      wr(3, 1'b0, 16'h0AAA);
      wr(3, 1'b1, 16'h0080);
      expect_cnt("R10 no reload on cascade clear", 3, 16'h0100);
      repeat (5) @(negedge clk);
      expect_cnt("R10 resumes from held count", 3, 16'h0105);
      wr(3, 1'b1, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl_readback();
      t_freeze();
      t_no_rearm();
      t_prescale();
      t_overflow_irq();
      t_ovf_write();
      t_timer0_casc();
      t_chain();
      t_pause();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule